// File: doc/BRIEF.md
# Coprocessor Control and Status Register Bank

This block is the software-visible register bank of a four-channel, descriptor-driven coprocessor. It holds three global registers: control, status and channel control. It also holds one group of four registers for each channel: command pointer, semaphore, channel status and options. The register fields drive the coprocessor's internal engines, and the engines report completion, errors and semaphore use back into the bank. The bank raises one interrupt line when an enabled channel has a pending completion.

Every register can be reached at four consecutive word addresses. Address bits [3:2] select the kind of write:
- 0 is a plain write.
- 1 ORs the data into the register.
- 2 clears the bits that are set in the data.
- 3 inverts the bits that are set in the data.

Software can therefore change single bits without a read-modify-write sequence, even while the engines update the same register. A soft-reset bit forces the whole bank back to its reset state. A clock-gate bit is passed out as a field. Both bits come out of reset set.

Top module: `cop_regbank`

## Requirements
- R1: After reset, control reads 0xF000_0000 (soft reset bit 31 = 1, clock gate bit 30 = 1, capability bits 29 and 28 = 1 by default), and every other register reads 0.
- R2: A plain write (address bits [3:2] = 0) replaces only the implemented bits. Capability bits 29 (cipher) and 28 (hash) are read-only. Bits that are not implemented read 0.
- R3: A write at offset +0x4 ORs the data into the register.
- R4: A write at offset +0x8 clears the bits that are set in the data.
- R5: A write at offset +0xC inverts the bits that are set in the data.
- R6: A read at any of the +0x4, +0x8 or +0xC offsets returns the value of the base register.
- R7: The registers of channel c are at 0x100 + 0x40*c: pointer at +0x00, semaphore at +0x10, status at +0x20, options at +0x30. Control is at 0x000, status at 0x010, channel control at 0x020.
- R8: A pulse on done_i[c] sets pending bit c of the status register (bits 3:0). Only a clear-alias write (0x018) clears a pending bit. Other writes leave it unchanged. If a completion and a clear fall in the same cycle, the bit stays set.
- R9: irq_o is high when a pending bit and its enable in control bits 3:0 are both set. irq_o rises in the cycle after the completion pulse.
- R10: While control bit 31 is 1, every register other than control holds its reset value and ignores writes. The rest of control returns to its reset value unless control itself is written in that cycle.
- R11: The semaphore is SEMA_W bits wide (8 by default). A high sema_dec_i[c] lowers the semaphore of channel c by one per cycle, and the value stops at 0. A software write in the same cycle takes precedence over the decrement.
- R12: A bit set on ch_stat_set_i sets the matching bit of that channel's status register, and that bit stays set. A clear-alias write at +0x28 removes it. If a set and a clear fall in the same cycle, the bit stays set.
- R13: The status register shows ready_i in bits 19:16, cur_ch_i in bits 27:24 and key_ready_i in bit 28.
- R14: Each control field comes out on a port:
  - control bits 23:21 on ctrl_mode_o, as {gather write, context cache, context switch}
  - control bit 30 on clk_gate_o
  - channel-control bits 3:0 on ch_en_o
  - channel-control bits 11:8 on ch_prio_o
  - channel-control bit 16 on ch0_merge_o
  
  Channel control reads back 0x0001_0F0F after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Byte address; bits [3:2] select the alias |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| done_i | input | NCH | Per-channel completion pulses |
| ready_i | input | NCH | Per-channel ready indication, shown in status |
| cur_ch_i | input | 4 | Channel currently being served, shown in status |
| key_ready_i | input | 1 | Key-ready indication, shown in status |
| sema_dec_i | input | NCH | Per-channel semaphore decrement request |
| ch_stat_set_i | input | NCH*32 | Per-channel status bits to set |
| irq_o | output | 1 | Interrupt request |
| soft_rst_o | output | 1 | Soft-reset field |
| clk_gate_o | output | 1 | Clock-gate field |
| ctrl_mode_o | output | 3 | {gather write, context cache, context switch} |
| ch_en_o | output | NCH | Channel enables |
| ch_prio_o | output | NCH | Channel high-priority flags |
| ch0_merge_o | output | 1 | Channel 0 interrupt merge flag |
| ch_ptr_o | output | NCH*32 | Command pointers, channel 0 in the low word |
| ch_opt_o | output | NCH*32 | Channel options |
| ch_sema_o | output | NCH*SEMA_W | Semaphore counts |

## Verification
Two updates can land on the same register in the same cycle:
- A completion pulse and a software clear of the pending bit.
- A semaphore decrement and a software write of the semaphore.

The bench drives both members of each pair in one clock cycle. It then reads the register back. The pending bit must still be set, and the semaphore must hold the written value with no decrement applied. The same kind of collision is produced on the sticky channel status bits.

// File: rtl/cop_regbank_pkg.sv
package cop_regbank_pkg;

  // Alias kind carried in address bits [3:2]
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_FLIP  = 2'b11
  } alias_op_e;

  // Register slot inside a channel group, address bits [5:4]
  localparam int unsigned SLOT_PTR  = 0;
  localparam int unsigned SLOT_SEMA = 1;
  localparam int unsigned SLOT_STAT = 2;
  localparam int unsigned SLOT_OPT  = 3;

  // Word index (address bits above [3:0]) of the global registers
  localparam logic [5:0] IDX_CTRL   = 6'h00;
  localparam logic [5:0] IDX_STAT   = 6'h01;
  localparam logic [5:0] IDX_CHCTRL = 6'h02;

  // Field positions that software and engines decode
  localparam int unsigned BIT_SRST     = 31;
  localparam int unsigned BIT_CGATE    = 30;
  localparam int unsigned BIT_CAP_CIPH = 29;
  localparam int unsigned BIT_CAP_HASH = 28;
  localparam int unsigned BIT_MODE_LO  = 21;
  localparam int unsigned BIT_PRIO_LO  = 8;
  localparam int unsigned BIT_MERGE0   = 16;
  localparam int unsigned BIT_READY_LO = 16;
  localparam int unsigned BIT_CUR_LO   = 24;
  localparam int unsigned BIT_KEYRDY   = 28;

endpackage

// File: rtl/cop_alias_reg.sv
module cop_alias_reg
  import cop_regbank_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] WMASK   = '1,
  parameter bit           CLR_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         we,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);

  logic [W-1:0] sw_val;
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    unique case (op)
      OP_WRITE: sw_val = wdata;
      OP_SET:   sw_val = q | wdata;
      OP_CLEAR: sw_val = q & ~wdata;
      default:  sw_val = q ^ wdata;
    endcase
    if (CLR_ONLY && (op != OP_CLEAR)) sw_val = q;

    en = hold | we | (|hw_set);
    if (hold) begin
      d = RST_VAL;
    end else begin
      d = q;
      if (we) d = (q & ~WMASK) | (sw_val & WMASK);
      d = d | hw_set;   // engine set beats a same-cycle software clear
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end

endmodule

// File: rtl/cop_chan_group.sv
module cop_chan_group
  import cop_regbank_pkg::*;
#(
  parameter int unsigned SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [3:0]        slot_we,
  input  alias_op_e         op,
  input  logic [31:0]       wdata,
  input  logic              sema_dec,
  input  logic [31:0]       stat_set,
  output logic [31:0]       ptr_o,
  output logic [SEMA_W-1:0] sema_o,
  output logic [31:0]       stat_o,
  output logic [31:0]       opt_o
);

  cop_alias_reg #(.W(32)) u_ptr (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(slot_we[SLOT_PTR]), .op(op),
    .wdata(wdata), .hw_set(32'h0), .q(ptr_o)
  );

  cop_alias_reg #(.W(32)) u_stat (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(slot_we[SLOT_STAT]), .op(op),
    .wdata(wdata), .hw_set(stat_set), .q(stat_o)
  );

  cop_alias_reg #(.W(32)) u_opt (
    .clk(clk), .rst_n(rst_n), .hold(hold), .we(slot_we[SLOT_OPT]), .op(op),
    .wdata(wdata), .hw_set(32'h0), .q(opt_o)
  );

  // Semaphore: software alias writes, engine decrement saturating at zero
  logic [SEMA_W-1:0] sema_q, sema_d, sema_sw;
  logic [SEMA_W-1:0] wsema;
  logic              sema_en;

  assign wsema = wdata[SEMA_W-1:0];

  always_comb begin
    unique case (op)
      OP_WRITE: sema_sw = wsema;
      OP_SET:   sema_sw = sema_q | wsema;
      OP_CLEAR: sema_sw = sema_q & ~wsema;
      default:  sema_sw = sema_q ^ wsema;
    endcase
    sema_en = hold | slot_we[SLOT_SEMA] | (sema_dec && (sema_q != '0));
    if (hold)                    sema_d = '0;
    else if (slot_we[SLOT_SEMA]) sema_d = sema_sw;
    else                         sema_d = sema_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sema_q <= '0;
    else if (sema_en) sema_q <= sema_d;
  end

  assign sema_o = sema_q;

endmodule

// File: rtl/cop_regbank.sv
module cop_regbank
  import cop_regbank_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned SEMA_W     = 8,
  parameter bit          HAS_CIPHER = 1'b1,
  parameter bit          HAS_HASH   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NCH-1:0]        done_i,
  input  logic [NCH-1:0]        ready_i,
  input  logic [3:0]            cur_ch_i,
  input  logic                  key_ready_i,
  input  logic [NCH-1:0]        sema_dec_i,
  input  logic [NCH*32-1:0]     ch_stat_set_i,
  output logic                  irq_o,
  output logic                  soft_rst_o,
  output logic                  clk_gate_o,
  output logic [2:0]            ctrl_mode_o,
  output logic [NCH-1:0]        ch_en_o,
  output logic [NCH-1:0]        ch_prio_o,
  output logic                  ch0_merge_o,
  output logic [NCH*32-1:0]     ch_ptr_o,
  output logic [NCH*32-1:0]     ch_opt_o,
  output logic [NCH*SEMA_W-1:0] ch_sema_o
);

  localparam int unsigned CH_W     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [31:0] NCH_MASK = (32'd1 << NCH) - 32'd1;
  localparam logic [31:0] CTRL_RST = (32'd1 << BIT_SRST) | (32'd1 << BIT_CGATE);
  localparam logic [31:0] CTRL_WM  = CTRL_RST | (32'd7 << BIT_MODE_LO) | NCH_MASK;
  localparam logic [31:0] CHC_WM   = (32'd1 << BIT_MERGE0) | (NCH_MASK << BIT_PRIO_LO) | NCH_MASK;
  localparam logic [31:0] CAPS     = (HAS_CIPHER ? (32'd1 << BIT_CAP_CIPH) : 32'd0) |
                                     (HAS_HASH   ? (32'd1 << BIT_CAP_HASH) : 32'd0);

  // Reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  // Address decode
  alias_op_e          wr_op;
  logic [5:0]         idx;
  logic               ch_hit;
  logic [CH_W-1:0]    ch_idx;
  logic [1:0]         slot;
  logic               ctrl_we, stat_we, chc_we;

  assign wr_op   = alias_op_e'(bus_addr[3:2]);
  assign idx     = bus_addr[9:4];
  assign ch_hit  = (bus_addr[ADDR_W-1:8] == (ADDR_W-8)'(1)) && (int'(bus_addr[7:6]) < NCH);
  assign ch_idx  = bus_addr[6 +: CH_W];
  assign slot    = bus_addr[5:4];
  assign ctrl_we = bus_we && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(IDX_CTRL));
  assign stat_we = bus_we && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(IDX_STAT));
  assign chc_we  = bus_we && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(IDX_CHCTRL));

  // Global registers
  logic [31:0]    ctrl_q, chctrl_q;
  logic [NCH-1:0] pend_q;
  logic           srst;
  logic           hold_ctrl;

  assign srst      = ctrl_q[BIT_SRST];
  assign hold_ctrl = srst & ~ctrl_we;

  cop_alias_reg #(.W(32), .RST_VAL(CTRL_RST), .WMASK(CTRL_WM)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .hold(hold_ctrl), .we(ctrl_we), .op(wr_op),
    .wdata(bus_wdata), .hw_set(32'h0), .q(ctrl_q)
  );

  cop_alias_reg #(.W(NCH), .CLR_ONLY(1'b1)) u_pend (
    .clk(clk), .rst_n(rst_n_int), .hold(srst), .we(stat_we), .op(wr_op),
    .wdata(bus_wdata[NCH-1:0]), .hw_set(done_i), .q(pend_q)
  );

  cop_alias_reg #(.W(32), .WMASK(CHC_WM)) u_chctrl (
    .clk(clk), .rst_n(rst_n_int), .hold(srst), .we(chc_we), .op(wr_op),
    .wdata(bus_wdata), .hw_set(32'h0), .q(chctrl_q)
  );

  // Channel groups
  logic [31:0]       ptr_arr  [NCH];
  logic [31:0]       stat_arr [NCH];
  logic [31:0]       opt_arr  [NCH];
  logic [SEMA_W-1:0] sema_arr [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [3:0] slot_we;
    assign slot_we = (bus_we && ch_hit && (ch_idx == CH_W'(c))) ? (4'b0001 << slot) : 4'b0000;

    cop_chan_group #(.SEMA_W(SEMA_W)) u_grp (
      .clk(clk), .rst_n(rst_n_int), .hold(srst), .slot_we(slot_we), .op(wr_op),
      .wdata(bus_wdata), .sema_dec(sema_dec_i[c]), .stat_set(ch_stat_set_i[c*32 +: 32]),
      .ptr_o(ptr_arr[c]), .sema_o(sema_arr[c]), .stat_o(stat_arr[c]), .opt_o(opt_arr[c])
    );

    assign ch_ptr_o[c*32 +: 32]          = ptr_arr[c];
    assign ch_opt_o[c*32 +: 32]          = opt_arr[c];
    assign ch_sema_o[c*SEMA_W +: SEMA_W] = sema_arr[c];
  end

  // Status view: pending flags plus live engine indications
  logic [31:0] stat_view;
  always_comb begin
    stat_view                       = '0;
    stat_view[NCH-1:0]              = pend_q;
    stat_view[BIT_READY_LO +: NCH]  = ready_i;
    stat_view[BIT_CUR_LO +: 4]      = cur_ch_i;
    stat_view[BIT_KEYRDY]           = key_ready_i;
  end

  // Read mux, alias bits ignored
  always_comb begin
    bus_rdata = '0;
    if (ch_hit) begin
      unique case (slot)
        2'd0:    bus_rdata = ptr_arr[ch_idx];
        2'd1:    bus_rdata = 32'(sema_arr[ch_idx]);
        2'd2:    bus_rdata = stat_arr[ch_idx];
        default: bus_rdata = opt_arr[ch_idx];
      endcase
    end else if (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(IDX_CTRL)) begin
      bus_rdata = ctrl_q | CAPS;
    end else if (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(IDX_STAT)) begin
      bus_rdata = stat_view;
    end else if (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(IDX_CHCTRL)) begin
      bus_rdata = chctrl_q;
    end
  end

  // Field outputs
  assign irq_o       = |(pend_q & ctrl_q[NCH-1:0]);
  assign soft_rst_o  = srst;
  assign clk_gate_o  = ctrl_q[BIT_CGATE];
  assign ctrl_mode_o = ctrl_q[BIT_MODE_LO +: 3];
  assign ch_en_o     = chctrl_q[NCH-1:0];
  assign ch_prio_o   = chctrl_q[BIT_PRIO_LO +: NCH];
  assign ch0_merge_o = chctrl_q[BIT_MERGE0];

endmodule

// File: rtl/cop_regbank_chk.sv
module cop_regbank_chk #(
  parameter int unsigned NCH        = 4,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned SEMA_W     = 8,
  parameter bit          HAS_CIPHER = 1'b1,
  parameter bit          HAS_HASH   = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [31:0]           bus_rdata,
  input logic [NCH-1:0]        done_i,
  input logic [NCH-1:0]        sema_dec_i,
  input logic                  irq_o,
  input logic                  soft_rst_o,
  input logic [NCH-1:0]        ch_en_o,
  input logic [NCH*32-1:0]     ch_ptr_o,
  input logic [NCH*SEMA_W-1:0] ch_sema_o,
  input logic [31:0]           ctrl_q
);

  AST_CAPS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[ADDR_W-1:4] == '0) |-> (bus_rdata[29:28] == {HAS_CIPHER, HAS_HASH})); // R2

  AST_PEND_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !bus_we && !soft_rst_o) |=> irq_o); // R8

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(done_i & ctrl_q[NCH-1:0])) && !soft_rst_o && !bus_we) |=> irq_o); // R9

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> ((ch_ptr_o == '0) && (ch_en_o == '0))); // R10

  for (genvar c = 0; c < NCH; c++) begin : g_sema
    AST_SEMA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sema_dec_i[c] && !bus_we && !soft_rst_o && (ch_sema_o[c*SEMA_W +: SEMA_W] != '0))
      |=> (ch_sema_o[c*SEMA_W +: SEMA_W] == SEMA_W'($past(ch_sema_o[c*SEMA_W +: SEMA_W]) - 1'b1))); // R11

    AST_SEMA_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && (ch_sema_o[c*SEMA_W +: SEMA_W] == '0))
      |=> (ch_sema_o[c*SEMA_W +: SEMA_W] == '0)); // R11
  end

endmodule

bind cop_regbank cop_regbank_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .SEMA_W(SEMA_W), .HAS_CIPHER(HAS_CIPHER), .HAS_HASH(HAS_HASH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .done_i(done_i), .sema_dec_i(sema_dec_i), .irq_o(irq_o), .soft_rst_o(soft_rst_o),
  .ch_en_o(ch_en_o), .ch_ptr_o(ch_ptr_o), .ch_sema_o(ch_sema_o), .ctrl_q(ctrl_q)
);

// File: tb/cop_regbank_test.sv
module cop_regbank_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int SEMA_W     = 8;

  logic                  clk;
  logic                  rst_n;
  logic [9:0]            bus_addr;
  logic                  bus_we;
  logic [31:0]           bus_wdata;
  logic [31:0]           bus_rdata;
  logic [NCH-1:0]        done_i, ready_i, sema_dec_i;
  logic [3:0]            cur_ch_i;
  logic                  key_ready_i;
  logic [NCH*32-1:0]     ch_stat_set_i;
  logic                  irq_o, soft_rst_o, clk_gate_o, ch0_merge_o;
  logic [2:0]            ctrl_mode_o;
  logic [NCH-1:0]        ch_en_o, ch_prio_o;
  logic [NCH*32-1:0]     ch_ptr_o, ch_opt_o;
  logic [NCH*SEMA_W-1:0] ch_sema_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cop_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done_i(done_i), .ready_i(ready_i), .cur_ch_i(cur_ch_i),
    .key_ready_i(key_ready_i), .sema_dec_i(sema_dec_i), .ch_stat_set_i(ch_stat_set_i),
    .irq_o(irq_o), .soft_rst_o(soft_rst_o), .clk_gate_o(clk_gate_o), .ctrl_mode_o(ctrl_mode_o),
    .ch_en_o(ch_en_o), .ch_prio_o(ch_prio_o), .ch0_merge_o(ch0_merge_o),
    .ch_ptr_o(ch_ptr_o), .ch_opt_o(ch_opt_o), .ch_sema_o(ch_sema_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl reset", 10'h000, 32'hF000_0000);
    rd_chk("R1 status reset", 10'h010, 32'h0);
    rd_chk("R1 chctrl reset", 10'h020, 32'h0);
    check("R1 soft_rst_o", 32'(soft_rst_o), 32'h1);
    check("R1 clk_gate_o", 32'(clk_gate_o), 32'h1);
    wr(10'h100, 32'h0000_1234);
    rd_chk("R10 write ignored in soft reset", 10'h100, 32'h0);
    wr(10'h008, 32'hC000_0000);
    rd_chk("R4 ctrl after clear alias", 10'h000, 32'h3000_0000);
    check("R14 clk_gate_o cleared", 32'(clk_gate_o), 32'h0);
    wr(10'h100, 32'h0000_1234);
    rd_chk("R7 ptr0 after soft reset release", 10'h100, 32'h0000_1234);
  endtask

  task automatic t_plain;
    wr(10'h000, 32'h3FFF_FFFF);
    rd_chk("R2 ctrl masked write", 10'h000, 32'h30E0_000F);
    check("R14 ctrl_mode_o", 32'(ctrl_mode_o), 32'h7);
    wr(10'h000, 32'h0);
    rd_chk("R2 caps survive zero write", 10'h000, 32'h3000_0000);
    wr(10'h020, 32'hFFFF_FFFF);
    rd_chk("R14 chctrl mask", 10'h020, 32'h0001_0F0F);
    check("R14 ch_en_o", 32'(ch_en_o), 32'hF);
    check("R14 ch_prio_o", 32'(ch_prio_o), 32'hF);
    check("R14 ch0_merge_o", 32'(ch0_merge_o), 32'h1);
    wr(10'h020, 32'h0);
  endtask

  task automatic t_alias;
    wr(10'h1B0, 32'h0000_00F0);
    wr(10'h1B4, 32'h0F00_000F);
    rd_chk("R3 set alias", 10'h1B0, 32'h0F00_00FF);
    wr(10'h1B8, 32'h0000_00F0);
    rd_chk("R4 clear alias", 10'h1B0, 32'h0F00_000F);
    wr(10'h1BC, 32'hFF00_0001);
    rd_chk("R5 toggle alias", 10'h1B0, 32'hF000_000E);
    rd_chk("R6 read at +4", 10'h1B4, 32'hF000_000E);
    rd_chk("R6 read at +C", 10'h1BC, 32'hF000_000E);
    check("R5 ch_opt_o ch2", ch_opt_o[2*32 +: 32], 32'hF000_000E);
  endtask

  task automatic t_groups;
    for (int c = 0; c < NCH; c++) begin
      wr(10'(32'h100 + 32'h40*c), 32'hA0 + c);
      wr(10'(32'h130 + 32'h40*c), 32'hC0 + c);
    end
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R7 ptr readback", 10'(32'h100 + 32'h40*c), 32'hA0 + c);
      rd_chk("R7 opt readback", 10'(32'h130 + 32'h40*c), 32'hC0 + c);
      check("R7 ch_ptr_o slice", ch_ptr_o[c*32 +: 32], 32'hA0 + c);
    end
  endtask

  task automatic t_pending;
    wr(10'h004, 32'h0000_0002);
    @(negedge clk); done_i = 4'b0010;
    @(negedge clk); done_i = 4'b0000;
    #1 check("R9 irq after done", 32'(irq_o), 32'h1);
    rd_chk("R8 pending set", 10'h010, 32'h0000_0002);
    wr(10'h010, 32'h0);
    rd_chk("R8 plain write ignored", 10'h010, 32'h0000_0002);
    wr(10'h014, 32'hF);
    rd_chk("R8 set alias ignored", 10'h010, 32'h0000_0002);
    wr(10'h018, 32'h2);
    rd_chk("R8 clear alias", 10'h010, 32'h0);
    check("R9 irq low after clear", 32'(irq_o), 32'h0);
    @(negedge clk);
    bus_addr = 10'h018; bus_wdata = 32'h2; bus_we = 1'b1; done_i = 4'b0010;
    @(negedge clk);
    bus_we = 1'b0; done_i = 4'b0000;
    rd_chk("R8 done beats same-cycle clear", 10'h010, 32'h0000_0002);
    wr(10'h018, 32'h2);
    @(negedge clk); done_i = 4'b0100;
    @(negedge clk); done_i = 4'b0000;
    #1 check("R9 disabled channel no irq", 32'(irq_o), 32'h0);
    rd_chk("R8 pending ch2", 10'h010, 32'h0000_0004);
    wr(10'h018, 32'hF);
    wr(10'h008, 32'hF);
  endtask

  task automatic t_status_view;
    ready_i = 4'b0101; cur_ch_i = 4'h3; key_ready_i = 1'b1;
    rd_chk("R13 status fields", 10'h010, 32'h1305_0000);
    ready_i = '0; cur_ch_i = '0; key_ready_i = 1'b0;
  endtask

  task automatic t_sema;
    wr(10'h1D0, 32'h0000_01FF);
    rd_chk("R11 sema width", 10'h1D0, 32'h0000_00FF);
    wr(10'h1D0, 32'h3);
    sema_dec_i = 4'b1000;
    @(negedge clk);
    @(negedge clk);
    #1 check("R11 two decrements", 32'(ch_sema_o[3*SEMA_W +: SEMA_W]), 32'h1);
    repeat (3) @(negedge clk);
    #1 check("R11 floor at zero", 32'(ch_sema_o[3*SEMA_W +: SEMA_W]), 32'h0);
    @(negedge clk);
    bus_addr = 10'h1D0; bus_wdata = 32'h7; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; sema_dec_i = '0;
    #1 check("R11 write beats decrement", 32'(ch_sema_o[3*SEMA_W +: SEMA_W]), 32'h7);
  endtask

  task automatic t_chstat;
    @(negedge clk); ch_stat_set_i[32 +: 32] = 32'h40;
    @(negedge clk); ch_stat_set_i = '0;
    rd_chk("R12 sticky set", 10'h160, 32'h40);
    @(negedge clk);
    bus_addr = 10'h168; bus_wdata = 32'h40; bus_we = 1'b1; ch_stat_set_i[32 +: 32] = 32'h40;
    @(negedge clk);
    bus_we = 1'b0; ch_stat_set_i = '0;
    rd_chk("R12 set beats clear", 10'h160, 32'h40);
    wr(10'h168, 32'h40);
    rd_chk("R12 clear alias", 10'h160, 32'h0);
  endtask

  task automatic t_soft_reset;
    wr(10'h140, 32'h55);
    wr(10'h020, 32'h1);
    wr(10'h004, 32'h8000_0000);
    @(negedge clk);
    rd_chk("R10 ptr reset by soft reset", 10'h140, 32'h0);
    rd_chk("R10 chctrl reset", 10'h020, 32'h0);
    rd_chk("R10 ctrl back to reset", 10'h000, 32'hF000_0000);
    wr(10'h140, 32'h9);
    rd_chk("R10 write ignored", 10'h140, 32'h0);
    wr(10'h008, 32'hC000_0000);
    rd_chk("R10 released", 10'h000, 32'h3000_0000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    done_i = '0; ready_i = '0; cur_ch_i = '0; key_ready_i = 1'b0;
    sema_dec_i = '0; ch_stat_set_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_plain;
    t_alias;
    t_groups;
    t_pending;
    t_status_view;
    t_sema;
    t_chstat;
    t_soft_reset;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule